// File: doc/BRIEF.md
# Configuration Status Half-Word with Sticky Error Flags

This block holds the upper 16 bits of a PCI configuration command/status doubleword for a simple network function that acts as both target and master. Four error flags record bus events. Single-cycle pulses from the bus interface logic set these flags: a detected parity error, an asserted SERR#, a master abort on a transaction this device mastered, and a target abort on such a transaction. Each flag stays set until software writes a 1 to its bit position.

Every other bit of the half-word is fixed. The DEVSEL timing code reads as medium (01; the code is 00 fast, 01 medium, 10 slow, 11 reserved). The capabilities-list and fast back-to-back bits read as 1, and every remaining bit reads as 0. The configuration write port carries the half-word data and two byte enables: enable 1 covers bits 15:8 (doubleword bits 31:24) and enable 0 covers bits 7:0 (doubleword bits 23:16). The read port returns the composed value combinationally from the flag registers.

Top module: `cfg_status_hi`

## Requirements
- R1: After reset, rd_data equals 16'h0290: all four flags are clear and the fixed fields hold their values.
- R2: A parity pulse (par_err_evt) sets rd_data[15] on the next clock edge. No enable gates this flag.
- R3: A system error pulse (serr_evt) sets rd_data[14] on the next clock edge.
- R4: A master-abort pulse (mabort_evt) sets rd_data[13], and a target-abort pulse (tabort_evt) sets rd_data[12], each on the next clock edge.
- R5: A set flag stays set across any number of cycles until a clear reaches that bit.
- R6: A write with wr_en=1 and wr_be[1]=1 clears, on the next edge, each flag in rd_data[15:12] whose wr_data bit is 1. A flag whose wr_data bit is 0 keeps its value.
- R7: A write with wr_be[1]=0 leaves all flags unchanged, whatever the data.
- R8: When a set pulse and a clearing write hit the same flag in the same cycle, the flag is set after the edge.
- R9: rd_data[11:0] always reads 12'h290 (bit 11 = 0 signaled target abort, bits 10:9 = 01 medium DEVSEL, bit 8 = 0, bit 7 = 1 fast back-to-back, bits 6:5 = 0, bit 4 = 1 capabilities, bits 3:0 = 0). Writes with any data and enables do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_err_evt | input | 1 | Parity error detected pulse |
| serr_evt | input | 1 | SERR# asserted pulse |
| mabort_evt | input | 1 | Own transaction ended in master abort |
| tabort_evt | input | 1 | Own transaction ended in target abort |
| wr_en | input | 1 | Configuration write strobe |
| wr_be | input | 2 | Byte enables: [1] bits 15:8, [0] bits 7:0 |
| wr_data | input | 16 | Configuration write data |
| rd_data | output | 16 | Composed status value |

## Verification
The hardest case to reach is a set pulse and a clearing write that land on the same flag in one cycle. It needs an already set flag, an event pulse and a write with the upper enable, all aligned to one edge. The stimulus first sets all flags and then drives an event together with an all-ones clear for each flag in turn, so the event must survive the clear. It also issues writes with only the lower enable, and writes of all ones and all zeros, to show that neither the flags nor the fixed fields move.

// File: rtl/cfg_status_hi.sv
module cfg_status_hi #(
  parameter int NFLAG = 4,
  parameter logic [15:0] FIXED = 16'h0290
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        par_err_evt,
  input  logic        serr_evt,
  input  logic        mabort_evt,
  input  logic        tabort_evt,
  input  logic        wr_en,
  input  logic [1:0]  wr_be,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data
);
  localparam int LO = 16 - NFLAG;

  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] clr_v;

  assign set_v = {par_err_evt, serr_evt, mabort_evt, tabort_evt};
  assign clr_v = (wr_en && wr_be[1]) ? wr_data[15:LO] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_v) | set_v;
  end

  assign rd_data = {flags, FIXED[LO-1:0]};

  logic unused_bits;
  assign unused_bits = &{1'b0, wr_be[0], wr_data[LO-1:0], FIXED[15:LO]};
endmodule

module cfg_status_hi_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        par_err_evt,
  input logic        serr_evt,
  input logic        mabort_evt,
  input logic        tabort_evt,
  input logic        wr_en,
  input logic [1:0]  wr_be,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data
);
  assert_par_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    par_err_evt |=> rd_data[15]);
  assert_serr_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    serr_evt |=> rd_data[14]);
  assert_abort_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mabort_evt || tabort_evt) |=> ((!$past(mabort_evt) || rd_data[13]) && (!$past(tabort_evt) || rd_data[12])));
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[15] && !(wr_en && wr_be[1] && wr_data[15])) |=> rd_data[15]);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[1] && wr_data[14] && !serr_evt) |=> !rd_data[14]);
  assert_no_be_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && wr_be[1]) && !mabort_evt) |=> $stable(rd_data[13]));
  assert_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[11:0] == 12'h290);
endmodule

bind cfg_status_hi cfg_status_hi_chk u_chk (.*);

// File: tb/cfg_status_hi_test.sv
`timescale 1ns/1ps
module cfg_status_hi_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic par = 0, serr = 0, ma = 0, ta = 0, we = 0;
  logic [1:0] be = 0;
  logic [15:0] wd = 0;
  logic [15:0] rd_data;
  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R1";
  bit m_par = 0, m_serr = 0, m_ma = 0, m_ta = 0;

  always #10 clk = ~clk;

  cfg_status_hi uut (.clk(clk), .rst_n(rst_n), .par_err_evt(par), .serr_evt(serr),
    .mabort_evt(ma), .tabort_evt(ta), .wr_en(we), .wr_be(be), .wr_data(wd),
    .rd_data(rd_data));

  function automatic logic [15:0] model_val();
    return {m_par, m_serr, m_ma, m_ta, 12'h290};
  endfunction

  always @(posedge clk) begin
    bit clr;
    clr = we && be[1];
    if (!rst_n) begin
      m_par = 0; m_serr = 0; m_ma = 0; m_ta = 0;
    end else begin
      if (clr && wd[15]) m_par = 0;
      if (clr && wd[14]) m_serr = 0;
      if (clr && wd[13]) m_ma = 0;
      if (clr && wd[12]) m_ta = 0;
      if (par) m_par = 1;
      if (serr) m_serr = 1;
      if (ma) m_ma = 1;
      if (ta) m_ta = 1;
    end
  end

  task automatic chk(string req, logic [15:0] exp);
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) chk(cur_req, model_val());

  task automatic step(bit p, bit s, bit m, bit t, bit w, logic [1:0] b, logic [15:0] d);
    @(negedge clk);
    par = p; serr = s; ma = m; ta = t; we = w; be = b; wd = d;
    @(posedge clk); #2;
    par = 0; serr = 0; ma = 0; ta = 0; we = 0; be = 0; wd = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: cycles=%0d expected=finish", cycles);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk); #2;
    rst_n = 1;
    chk("R1", 16'h0290);
    cur_req = "R2"; step(1,0,0,0,0,2'b00,0); chk("R2", 16'h8290);
    cur_req = "R3"; step(0,1,0,0,0,2'b00,0); chk("R3", 16'hC290);
    cur_req = "R4"; step(0,0,1,0,0,2'b00,0); chk("R4", 16'hE290);
    step(0,0,0,1,0,2'b00,0); chk("R4", 16'hF290);
    cur_req = "R5"; repeat (10) step(0,0,0,0,0,2'b00,0); chk("R5", 16'hF290);
    cur_req = "R7"; step(0,0,0,0,1,2'b01,16'hFFFF); chk("R7", 16'hF290);
    step(0,0,0,0,0,2'b10,16'hFFFF); chk("R7", 16'hF290);
    cur_req = "R6"; step(0,0,0,0,1,2'b10,16'h0000); chk("R6", 16'hF290);
    step(0,0,0,0,1,2'b10,16'h5000); chk("R6", 16'hA290);
    step(0,0,0,0,1,2'b10,16'hA000); chk("R6", 16'h0290);
    cur_req = "R8"; step(1,1,1,1,0,2'b00,0);
    step(1,0,0,0,1,2'b10,16'hF000); chk("R8", 16'h8290);
    step(0,1,0,0,1,2'b11,16'hFFFF); chk("R8", 16'h4290);
    step(0,0,1,1,1,2'b10,16'hF000); chk("R8", 16'h3290);
    cur_req = "R9"; step(0,0,0,0,1,2'b11,16'h0D6F); chk("R9", 16'h3290);
    step(0,0,0,0,1,2'b11,16'h0000); chk("R9", 16'h3290);
    step(0,0,0,0,1,2'b11,16'h3FFF); chk("R9", 16'h0290);
    cur_req = "R2"; step(1,0,0,1,0,2'b00,0); chk("R2", 16'h9290);
    cur_req = "R1"; @(negedge clk); rst_n = 0; @(posedge clk); #2; rst_n = 1;
    chk("R1", 16'h0290);
    repeat (2) @(posedge clk);
    finish_run();
  end

  always @(posedge clk) cycles++;
endmodule